// File: doc/BRIEF.md
# USB OUT Data Packet Buffer Writer

This block sits behind the receive path of a USB device controller. Once an OUT token has selected an endpoint, the block takes the decoded bytes of the DATA packet that follows and writes them into that endpoint's buffer RAM through a plain write port. The bytes run from the first payload byte through the two trailing CRC-16 bytes. Before the first byte, a start pulse loads the buffer base address and a 3-bit code that sets the endpoint's maximum packet size.

Upstream logic flags bit-stuff and CRC faults. At end of packet the block gives a one-cycle verdict. On success it requests an ACK handshake and records the number of payload bytes. On any fault it stays silent, so that the receiver can go back to waiting for the next token.

The block never knows which bytes are CRC until the packet ends. It therefore stores every byte whose position in the stream lies below the configured size. The result is that payloads well under the limit keep both CRC bytes, a payload one short of the limit keeps the first CRC byte only, and a full or oversized payload keeps no CRC byte. A start pulse that arrives while a packet is already open is ignored.

Top module: `usb_out_pkt_writer`

## Requirements
- R1: Out of reset, mem_we, done, ok and ack_req are 0 and byte_count is 0.
- R2: Bytes are taken only while a packet is open, meaning after the cycle of an accepted pkt_start and up to pkt_end. A byte presented while idle, or in the same cycle as pkt_start, writes nothing.
- R3: The maximum size S is decoded from size_code: codes 0 to 6 give 8 shifted left by the code (8 to 512), and code 7 gives 1023.
- R4: Stream byte number i (0 is the first payload byte) is written to base_addr+i, one cycle after it is presented, if and only if i < S. Successive writes of one packet use consecutive addresses.
- R5: When the payload count d is at most S-2, the payload and both CRC bytes are stored (d+2 writes).
- R6: When d equals S-1, the payload and only the first CRC byte are stored (S writes).
- R7: When d equals S, only the payload is stored (S writes, no CRC byte).
- R8: When d exceeds S, only the first S payload bytes are stored and the rest are dropped. Fault checking and the byte count still cover the whole packet.
- R9: If no fault is seen, then one cycle after pkt_end, done, ok and ack_req are 1 for exactly one cycle, and byte_count becomes d (the total bytes minus two).
- R10: If stuff_err or crc_err is high in any cycle while the packet is open (including the pkt_end cycle), then done is 1 with ok and ack_req at 0, and byte_count keeps its previous value.
- R11: A packet with fewer than two bytes is treated as faulty, as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Opens a packet; base and size are latched |
| base_addr | input | AW | Endpoint buffer base address |
| size_code | input | 3 | Maximum packet size code |
| rx_valid | input | 1 | A decoded byte is present |
| rx_byte | input | 8 | Decoded byte |
| stuff_err | input | 1 | Bit-stuff fault flag from the receiver |
| crc_err | input | 1 | CRC-16 fault flag from the receiver |
| pkt_end | input | 1 | End of the packet |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | AW | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle end-of-packet verdict strobe |
| ok | output | 1 | Verdict: packet good |
| ack_req | output | 1 | Request to send an ACK handshake |
| byte_count | output | CW | Payload bytes of the last good packet |

## Verification
The assertions assume that rx_valid and pkt_end are never high in the same cycle. They also assume that pkt_start comes only while the block is idle, and that at least one cycle separates the pkt_end cycle from the next pkt_start. The address checks depend on the latched base staying fixed while writes drain, so they rely on this spacing. The bench drives every packet through one task that spends a full cycle on the start pulse, then on each byte, and then on the end pulse. The only place it breaks the spacing is the byte it deliberately places in the start cycle.

// File: rtl/usb_outw_pkg.sv
// Shared constants and the size-code decoder for the OUT packet writer.
// Assumes: a size code is 3 bits wide; code 7 selects the 1023-byte limit.
package usb_outw_pkg;

    localparam int SIZE_CODE_W = 3;
    localparam int BASE_SIZE   = 8;
    localparam int TOP_SIZE    = 1023;

    // Maps a size code to a byte limit: 8 << code for 0..6, 1023 for 7.
    function automatic int size_of_code(input logic [SIZE_CODE_W-1:0] code);
        if (code == 3'd7) begin
            return TOP_SIZE;
        end
        return BASE_SIZE << code;
    endfunction

endpackage

// File: rtl/outw_ctrl.sv
// Packet framing control for the OUT packet writer.
// It opens a packet on pkt_start while idle, latches the base and the decoded
// size, and closes the packet on pkt_end.
// Assumes: pkt_start arrives only while idle; a start pulse during an open
// packet is ignored.
module outw_ctrl #(
    parameter int AW = 11,
    parameter int CW = 11
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  pkt_start,
    input  logic                                  pkt_end,
    input  logic [AW-1:0]                         base_addr,
    input  logic [usb_outw_pkg::SIZE_CODE_W-1:0]  size_code,
    output logic                                  active,
    output logic                                  clear,
    output logic                                  finish,
    output logic [AW-1:0]                         base_q,
    output logic [CW-1:0]                         size_q
);
    typedef enum logic { ST_IDLE, ST_RECV } ctrl_state_t;

    ctrl_state_t state;

    assign active = (state == ST_RECV);
    assign clear  = (state == ST_IDLE) && pkt_start;
    assign finish = (state == ST_RECV) && pkt_end;

    // State register: idle until a start pulse, receiving until the end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (clear) begin
            state <= ST_RECV;
        end else if (finish) begin
            state <= ST_IDLE;
        end
    end

    // Configuration capture: base and decoded size are held for the whole packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (clear) begin
            base_q <= base_addr;
            size_q <= CW'(usb_outw_pkg::size_of_code(size_code));
        end
    end

    // R2
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pkt_end) |=> !active);

    // R3
    size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (size_q >= CW'(8) && size_q <= CW'(1023)));

endmodule

// File: rtl/outw_store.sv
// Buffer write path for the OUT packet writer.
// It counts every byte of the open packet and writes the byte to base+index
// one cycle later when the index lies below the configured size. Because the
// last two stream bytes are CRC, this single cut leaves zero, one or two CRC
// bytes stored, depending on how close the payload is to the size.
// Assumes: no byte arrives in the same cycle as pkt_end.
module outw_store #(
    parameter int AW = 11,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [AW-1:0] base_q,
    input  logic [CW-1:0] size_q,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [CW-1:0] byte_total
);
    localparam logic [CW-1:0] TOTAL_MAX = '1;

    logic          take;
    logic          keep;
    logic [AW-1:0] off_w;

    assign take  = active && rx_valid;
    assign keep  = take && (byte_total < size_q);
    assign off_w = mem_addr - base_q;

    // Stream position counter; it saturates so a runaway packet cannot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_total <= '0;
        end else if (take && byte_total != TOTAL_MAX) begin
            byte_total <= byte_total + CW'(1);
        end
    end

    // Write port register: one write per kept byte, addressed base + position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= keep;
            if (keep) begin
                mem_addr  <= base_q + AW'(byte_total);
                mem_wdata <= rx_byte;
            end
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(off_w) < int'(size_q)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !mem_we);

endmodule

// File: rtl/outw_verdict.sv
// End-of-packet verdict for the OUT packet writer.
// It collects fault flags over the open packet and, one cycle after the
// packet closes, strobes done with the verdict, an ACK request and, on
// success only, the payload count (total bytes minus the two CRC bytes).
// Assumes: fault flags are meaningful only while a packet is open.
module outw_verdict #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          active,
    input  logic          finish,
    input  logic          stuff_err,
    input  logic          crc_err,
    input  logic [CW-1:0] byte_total,
    output logic          done,
    output logic          ok,
    output logic          ack_req,
    output logic [CW-1:0] byte_count
);
    logic err_seen;
    logic bad;

    assign bad = err_seen || stuff_err || crc_err || (byte_total < CW'(2));

    // Fault accumulator: set by any flag while the packet is open.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err_seen <= 1'b0;
        end else if (active && (stuff_err || crc_err)) begin
            err_seen <= 1'b1;
        end
    end

    // Verdict strobe and the ACK request, both valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            ok      <= 1'b0;
            ack_req <= 1'b0;
        end else begin
            done    <= finish;
            ok      <= finish && !bad;
            ack_req <= finish && !bad;
        end
    end

    // Payload count: written only for a good packet, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_count <= '0;
        end else if (finish && !bad) begin
            byte_count <= byte_total - CW'(2);
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(finish));

    // R10
    err_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> $stable(byte_count));

    // R10
    err_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && (stuff_err || crc_err)) |=> !ack_req);

endmodule

// File: rtl/usb_out_pkt_writer.sv
// Top of the USB OUT data packet buffer writer.
// It connects framing control, the buffer write path and the verdict unit.
// Assumes: rx_valid and pkt_end are never high together, and fault flags
// come from an upstream bit-stuff and CRC-16 checker.
module usb_out_pkt_writer #(
    parameter int AW = 11,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_start,
    input  logic [AW-1:0] base_addr,
    input  logic [2:0]    size_code,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          stuff_err,
    input  logic          crc_err,
    input  logic          pkt_end,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          done,
    output logic          ok,
    output logic          ack_req,
    output logic [CW-1:0] byte_count
);
    logic          active;
    logic          clear;
    logic          finish;
    logic [AW-1:0] base_q;
    logic [CW-1:0] size_q;
    logic [CW-1:0] byte_total;

    outw_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end),
        .base_addr (base_addr),
        .size_code (size_code),
        .active    (active),
        .clear     (clear),
        .finish    (finish),
        .base_q    (base_q),
        .size_q    (size_q)
    );

    outw_store #(.AW(AW), .CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .active     (active),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .base_q     (base_q),
        .size_q     (size_q),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .byte_total (byte_total)
    );

    outw_verdict #(.CW(CW)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .active     (active),
        .finish     (finish),
        .stuff_err  (stuff_err),
        .crc_err    (crc_err),
        .byte_total (byte_total),
        .done       (done),
        .ok         (ok),
        .ack_req    (ack_req),
        .byte_count (byte_count)
    );

    // R10
    ack_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (done && ok));

    // R2
    no_byte_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && pkt_end));

endmodule

// File: tb/tb_usb_out_pkt_writer.sv
// Directed bench for the OUT packet writer: one task per scenario.
module tb_usb_out_pkt_writer;
    localparam int AW = 11;
    localparam int CW = 11;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [2:0]    size_code = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          stuff_err = 1'b0;
    logic          crc_err = 1'b0;
    logic          pkt_end = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          done;
    logic          ok;
    logic          ack_req;
    logic [CW-1:0] byte_count;

    int errors = 0;
    int checks = 0;
    int wcount = 0;
    int last_count = 0;
    logic [7:0] model [DEPTH];

    usb_out_pkt_writer #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .base_addr(base_addr),
        .size_code(size_code), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .stuff_err(stuff_err), .crc_err(crc_err), .pkt_end(pkt_end),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .ok(ok), .ack_req(ack_req), .byte_count(byte_count)
    );

    always #2 clk = ~clk;

    // Write monitor: records buffer writes at the falling edge.
    always @(negedge clk) begin
        if (mem_we) begin
            model[mem_addr] = mem_wdata;
            wcount = wcount + 1;
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int size_of(input int code);
        return (code == 7) ? 1023 : (8 << code);
    endfunction

    function automatic logic [7:0] stream_byte(input int i, input int d);
        if (i == d)     return 8'hA5;
        if (i == d + 1) return 8'h5A;
        return 8'(i * 7 + 3);
    endfunction

    // Sends one packet of n bytes (payload plus CRC) and checks all results.
    task automatic send_pkt(input int code, input int base, input int n,
                            input int stuff_at, input bit crc_bad, input string req);
        int s;
        int d;
        int stored;
        int bad;
        bit good;
        int exp_count;
        s = size_of(code);
        d = n - 2;
        stored = (n < s) ? n : s;
        good = !(stuff_at >= 0 || crc_bad || n < 2);
        exp_count = good ? d : last_count;
        for (int k = 0; k < DEPTH; k++) model[k] = 8'hEE;
        wcount = 0;
        @(negedge clk);
        pkt_start = 1'b1; base_addr = AW'(base); size_code = 3'(code);
        @(negedge clk);
        pkt_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_byte = stream_byte(i, d);
            stuff_err = (i == stuff_at);
            @(negedge clk);
        end
        rx_valid = 1'b0; stuff_err = 1'b0;
        pkt_end = 1'b1; crc_err = crc_bad;
        @(negedge clk);
        pkt_end = 1'b0; crc_err = 1'b0;
        check(done == 1'b1, req, "done strobe", int'(done), 1);
        check(ok == good, req, "ok verdict", int'(ok), int'(good));
        check(ack_req == good, req, "ack_req", int'(ack_req), int'(good));
        check(int'(byte_count) == exp_count, req, "byte_count", int'(byte_count), exp_count);
        @(negedge clk);
        check(done == 1'b0 && ack_req == 1'b0, req, "strobe one cycle", int'(done), 0);
        check(wcount == stored, req, "write count", wcount, stored);
        bad = 0;
        for (int i = 0; i < stored; i++) begin
            if (model[(base + i) % DEPTH] !== stream_byte(i, d)) bad++;
        end
        if (stored < DEPTH && model[(base + stored) % DEPTH] !== 8'hEE) bad++;
        check(bad == 0, req, "buffer content mismatches", bad, 0);
        if (good) last_count = d;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mem_we == 0 && done == 0 && ok == 0 && ack_req == 0, "R1",
              "outputs idle in reset", int'(mem_we | done | ok | ack_req), 0);
        check(byte_count == 0, "R1", "byte_count reset", int'(byte_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: bytes while idle and in the start cycle are not stored.
    task automatic t_idle_bytes();
        wcount = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = 8'(i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(wcount == 0, "R2", "writes while idle", wcount, 0);
        check(done == 0, "R2", "no verdict while idle", int'(done), 0);
    endtask

    // R2, R11: a byte in the start cycle is dropped, leaving an empty packet.
    task automatic t_start_cycle_byte();
        wcount = 0;
        @(negedge clk);
        pkt_start = 1'b1; size_code = 3'd0; base_addr = AW'(16'h500);
        rx_valid = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        pkt_start = 1'b0; rx_valid = 1'b0; pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check(done == 1 && ok == 0 && ack_req == 0, "R11", "empty packet faulty",
              int'(ok), 0);
        check(int'(byte_count) == last_count, "R11", "count held", int'(byte_count), last_count);
        @(negedge clk);
        check(wcount == 0, "R2", "start-cycle byte stored", wcount, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_bytes();
        send_pkt(0, 16'h010, 7,  -1, 0, "R5");     // d=5,   S=8
        send_pkt(0, 16'h020, 9,  -1, 0, "R6");     // d=7,   S=8
        send_pkt(0, 16'h040, 10, -1, 0, "R7");     // d=8,   S=8
        send_pkt(1, 16'h080, 22, -1, 0, "R8");     // d=20,  S=16
        send_pkt(1, 16'h0C0, 12, -1, 1, "R10");    // CRC fault, count held
        send_pkt(2, 16'h0E0, 40, 36, 0, "R8 R10"); // stuff fault in dropped tail
        send_pkt(2, 16'h300, 34, -1, 0, "R3 R7");  // d=32,  S=32
        send_pkt(6, 16'h200, 512, -1, 0, "R3 R5"); // d=510, S=512
        send_pkt(7, 16'h100, 1024, -1, 0, "R3 R6 R4"); // d=1022, S=1023
        send_pkt(0, 16'h600, 1, -1, 0, "R11");     // single byte
        send_pkt(3, 16'h7F0, 20, -1, 0, "R4 R9");  // wraps the address space
        t_start_cycle_byte();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule